// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a 34-bit physical address by walking a two-level page table held in memory. A translation request carries the virtual address, the kind of access (load, store or instruction fetch), the privilege mode of the requester, the two permission modifiers (supervisor access to user pages, and "execute implies readable"), and a flag that allows hardware to set the accessed and dirty bits. The root table's page number comes in on a separate input from the address-translation control register.

The walker reads one 32-bit table entry at a time over a simple request/response memory port. Each response carries a protection-fault flag. When the accessed or dirty bit must be set, the walker issues an atomic compare-and-write, and the response reports whether the compare matched. The walk ends with a one-cycle completion pulse that carries either a physical address, a page fault or an access fault. An external shadow-stack protection check feeds its verdict into the walker, so that it takes its place in a fixed order of leaf checks.

Only one walk is in progress at a time. Requests are taken only while the walker is idle.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0 and `mem_req_valid` is 0. `req_ready` is 1 only while idle, and a `req_valid` seen while busy is ignored, so it starts no new walk and issues no memory access.
- R2: The first entry is read from {root_ppn, va[31:22], 2'b00}. Following a pointer entry, the second is read from {pte[31:10], va[21:12], 2'b00}. Entry bits are: valid 0, read 1, write 2, execute 3, user 4, global 5, accessed 6, dirty 7, software 9:8, page number 31:10.
- R3: A read response with `mem_rsp_pmp_fault`=1 ends the walk with an access fault.
- R4: An entry with valid=0, or with read=0 and write=1, ends the walk with a page fault. So does a pointer entry (read=0, execute=0) found at the second level.
- R5: A leaf at the first level whose pte[19:10] is nonzero is a misaligned superpage. It gives a page fault, and this check comes before every other leaf check.
- R6: With `req_priv`=0 (user), a leaf with user=0 is a page fault. With `req_priv`=1 (supervisor), a leaf with user=1 is a page fault for a fetch, and for a load or store when `req_sum`=0.
- R7: With `ss_fault`=1, a leaf that passes R5 and R6 ends with an access fault. This check comes before the R8 check.
- R8: `req_acc` is 0 for a load, 1 for a store and 2 for a fetch. A load needs read=1, or execute=1 together with `req_mxr`=1. A store needs write=1, and a fetch needs execute=1. Otherwise the result is a page fault.
- R9: If accessed=0, or the access is a store with dirty=0, and `req_hw_ad`=0, the result is a page fault and no write is issued.
- R10: With `req_hw_ad`=1, that case issues a write to the same address with `mem_req_cmp` set to the entry read and `mem_req_wdata` set to the entry with accessed set (and dirty set for a store). If `mem_rsp_cas_ok`=0, the same address is read again and the walk carries on from there. A write response with `mem_rsp_pmp_fault`=1 is an access fault.
- R11: On success pa[11:0]=va[11:0]. For a 4 KiB page pa[33:12]=pte[31:10]. For a first-level superpage pa[33:22]=pte[31:20] and pa[21:12]=va[21:12].
- R12: `done` is high for exactly one cycle per walk, with at most one of `page_fault` and `access_fault` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_va | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_priv | input | 1 | 0 user, 1 supervisor |
| req_sum | input | 1 | Supervisor may load/store user pages |
| req_mxr | input | 1 | Executable pages readable by loads |
| req_hw_ad | input | 1 | Hardware accessed/dirty update allowed |
| root_ppn | input | 22 | Root table page number |
| ss_fault | input | 1 | External shadow-stack check verdict for the current leaf |
| mem_req_valid | output | 1 | Memory access pulse |
| mem_req_we | output | 1 | 1 = compare-and-write, 0 = read |
| mem_req_addr | output | 34 | Entry address |
| mem_req_cmp | output | 32 | Expected old entry value |
| mem_req_wdata | output | 32 | New entry value |
| mem_rsp_valid | input | 1 | Memory response |
| mem_rsp_rdata | input | 32 | Entry read |
| mem_rsp_pmp_fault | input | 1 | Physical protection fault on the access |
| mem_rsp_cas_ok | input | 1 | Compare matched and write performed |
| done | output | 1 | Walk finished (one cycle) |
| pa | output | 34 | Physical address on success |
| page_fault | output | 1 | Page fault result |
| access_fault | output | 1 | Access fault result |

## Verification
Several leaf checks can fail on the same response, and only the earliest in the fixed order may decide the outcome. The bench builds entries that fail two checks together: a misaligned superpage while the shadow-stack input is asserted, a user-bit violation together with the shadow-stack input, and a shadow-stack failure on an entry that also lacks write permission. Because the outcomes differ between page fault and access fault, the bench's reference walk shows whether the order was kept. A failed compare-and-write is also provoked by changing the entry in the bench memory straight after it is read. The retry read and a result taken from the changed entry are then checked.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W   = 32;
    localparam int PTE_W  = 32;
    localparam int PPN_W  = 22;
    localparam int VPN_W  = 10;
    localparam int OFF_W  = 12;
    localparam int PTE_SZ_LOG = 2;
    localparam int PA_W   = PPN_W + OFF_W;
    localparam int SUPER_HI_W = PPN_W - VPN_W;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        logic [1:0]       sw;
        logic             d;
        logic             a;
        logic             g;
        logic             u;
        logic             x;
        logic             w;
        logic             r;
        logic             v;
    } pte_t;

    typedef enum logic [1:0] {
        LEAF_OK      = 2'd0,
        LEAF_NEED_AD = 2'd1,
        LEAF_PF      = 2'd2,
        LEAF_AF      = 2'd3
    } leaf_e;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD       = 3'd1,
        ST_RD_WAIT  = 3'd2,
        ST_CAS      = 3'd3,
        ST_CAS_WAIT = 3'd4,
        ST_DONE     = 3'd5
    } walk_st_e;

    typedef struct packed {
        logic [VA_W-1:0] va;
        acc_e            acc;
        logic            priv_s;
        logic            sum;
        logic            mxr;
        logic            hw_ad;
    } xlate_req_t;

    function automatic logic pte_bad(input pte_t p);
        return !p.v || (!p.r && p.w);
    endfunction

    function automatic logic pte_leaf(input pte_t p);
        return p.r || p.x;
    endfunction

    function automatic logic [VPN_W-1:0] vpn_of(input logic [VA_W-1:0] va, input logic lvl);
        return lvl ? va[VA_W-1 -: VPN_W] : va[OFF_W +: VPN_W];
    endfunction

endpackage

// File: rtl/ptw_leaf_check.sv
module ptw_leaf_check
    import ptw_pkg::*;
(
    input  pte_t  pte,
    input  logic  lvl,
    input  acc_e  acc,
    input  logic  priv_s,
    input  logic  sum,
    input  logic  mxr,
    input  logic  hw_ad,
    input  logic  ss_fault,
    output leaf_e verdict
);

    logic misaligned;
    logic user_bad;
    logic perm_bad;
    logic need_ad;

    always_comb begin
        misaligned = lvl && (pte.ppn[VPN_W-1:0] != '0);

        if (!priv_s)
            user_bad = !pte.u;
        else
            user_bad = pte.u && ((acc == ACC_FETCH) || !sum);

        unique case (acc)
            ACC_LOAD:  perm_bad = !(pte.r || (pte.x && mxr));
            ACC_STORE: perm_bad = !pte.w;
            ACC_FETCH: perm_bad = !pte.x;
            default:   perm_bad = 1'b1;
        endcase

        need_ad = !pte.a || ((acc == ACC_STORE) && !pte.d);

        if (misaligned)              verdict = LEAF_PF;
        else if (user_bad)           verdict = LEAF_PF;
        else if (ss_fault)           verdict = LEAF_AF;
        else if (perm_bad)           verdict = LEAF_PF;
        else if (need_ad && !hw_ad)  verdict = LEAF_PF;
        else if (need_ad)            verdict = LEAF_NEED_AD;
        else                         verdict = LEAF_OK;
    end

endmodule

// File: rtl/ptw_pa_build.sv
module ptw_pa_build
    import ptw_pkg::*;
(
    input  pte_t             pte,
    input  logic             lvl,
    input  logic [VA_W-1:0]  va,
    output logic [PA_W-1:0]  pa
);

    always_comb begin
        if (lvl)
            pa = {pte.ppn[PPN_W-1 -: SUPER_HI_W], va[OFF_W +: VPN_W], va[OFF_W-1:0]};
        else
            pa = {pte.ppn, va[OFF_W-1:0]};
    end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [VA_W-1:0]       req_va,
    input  logic [1:0]            req_acc,
    input  logic                  req_priv,
    input  logic                  req_sum,
    input  logic                  req_mxr,
    input  logic                  req_hw_ad,
    input  logic [PPN_W-1:0]      root_ppn,
    input  logic                  ss_fault,
    output logic                  mem_req_valid,
    output logic                  mem_req_we,
    output logic [PA_W-1:0]       mem_req_addr,
    output logic [PTE_W-1:0]      mem_req_cmp,
    output logic [PTE_W-1:0]      mem_req_wdata,
    input  logic                  mem_rsp_valid,
    input  logic [PTE_W-1:0]      mem_rsp_rdata,
    input  logic                  mem_rsp_pmp_fault,
    input  logic                  mem_rsp_cas_ok,
    output logic                  done,
    output logic [PA_W-1:0]       pa,
    output logic                  page_fault,
    output logic                  access_fault
);

    walk_st_e         st;
    xlate_req_t       rq;
    logic             lvl;
    logic [PPN_W-1:0] tbl_ppn;
    pte_t             pte_q;
    pte_t             pte_rsp;
    pte_t             pte_leaf_src;
    leaf_e            verdict;
    logic [PA_W-1:0]  pa_calc;
    logic [PA_W-1:0]  pa_q;
    logic             pf_q;
    logic             af_q;

    assign pte_rsp      = pte_t'(mem_rsp_rdata);
    assign pte_leaf_src = (st == ST_CAS_WAIT) ? pte_q : pte_rsp;

    ptw_leaf_check u_leaf (
        .pte      (pte_rsp),
        .lvl      (lvl),
        .acc      (rq.acc),
        .priv_s   (rq.priv_s),
        .sum      (rq.sum),
        .mxr      (rq.mxr),
        .hw_ad    (rq.hw_ad),
        .ss_fault (ss_fault),
        .verdict  (verdict)
    );

    ptw_pa_build u_pa (
        .pte (pte_leaf_src),
        .lvl (lvl),
        .va  (rq.va),
        .pa  (pa_calc)
    );

    // memory port, driven from state
    always_comb begin
        pte_t upd;
        upd             = pte_q;
        upd.a           = 1'b1;
        if (rq.acc == ACC_STORE)
            upd.d = 1'b1;
        mem_req_valid   = (st == ST_RD) || (st == ST_CAS);
        mem_req_we      = (st == ST_CAS);
        mem_req_addr    = {tbl_ppn, vpn_of(rq.va, lvl), {PTE_SZ_LOG{1'b0}}};
        mem_req_cmp     = pte_q;
        mem_req_wdata   = upd;
    end

    assign req_ready    = (st == ST_IDLE);
    assign done         = (st == ST_DONE);
    assign pa           = pa_q;
    assign page_fault   = pf_q;
    assign access_fault = af_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            rq      <= '0;
            lvl     <= 1'b1;
            tbl_ppn <= '0;
            pte_q   <= '0;
            pa_q    <= '0;
            pf_q    <= 1'b0;
            af_q    <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        rq.va     <= req_va;
                        rq.acc    <= acc_e'(req_acc);
                        rq.priv_s <= req_priv;
                        rq.sum    <= req_sum;
                        rq.mxr    <= req_mxr;
                        rq.hw_ad  <= req_hw_ad;
                        lvl       <= 1'b1;
                        tbl_ppn   <= root_ppn;
                        pa_q      <= '0;
                        pf_q      <= 1'b0;
                        af_q      <= 1'b0;
                        st        <= ST_RD;
                    end
                end
                ST_RD: st <= ST_RD_WAIT;
                ST_RD_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_pmp_fault) begin
                            af_q <= 1'b1;
                            st   <= ST_DONE;
                        end else if (pte_bad(pte_rsp)) begin
                            pf_q <= 1'b1;
                            st   <= ST_DONE;
                        end else if (pte_leaf(pte_rsp)) begin
                            unique case (verdict)
                                LEAF_PF: begin
                                    pf_q <= 1'b1;
                                    st   <= ST_DONE;
                                end
                                LEAF_AF: begin
                                    af_q <= 1'b1;
                                    st   <= ST_DONE;
                                end
                                LEAF_NEED_AD: begin
                                    pte_q <= pte_rsp;
                                    st    <= ST_CAS;
                                end
                                default: begin
                                    pa_q <= pa_calc;
                                    st   <= ST_DONE;
                                end
                            endcase
                        end else if (!lvl) begin
                            pf_q <= 1'b1;
                            st   <= ST_DONE;
                        end else begin
                            tbl_ppn <= pte_rsp.ppn;
                            lvl     <= 1'b0;
                            st      <= ST_RD;
                        end
                    end
                end
                ST_CAS: st <= ST_CAS_WAIT;
                ST_CAS_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_pmp_fault) begin
                            af_q <= 1'b1;
                            st   <= ST_DONE;
                        end else if (mem_rsp_cas_ok) begin
                            pa_q <= pa_calc;
                            st   <= ST_DONE;
                        end else begin
                            st <= ST_RD;
                        end
                    end
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !req_ready); // R1
    AST_ENTRY_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (mem_req_addr[1:0] == 2'b00)); // R2
    AST_NO_WRITE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_we) |-> rq.hw_ad); // R9
    AST_WRITE_SETS_ACCESSED: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_we) |-> (mem_req_wdata[6] && (mem_req_wdata != mem_req_cmp))); // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R12
    AST_ONE_FAULT: assert property (@(posedge clk) disable iff (rst)
        done |-> $countones({page_fault, access_fault}) <= 1); // R12
    AST_READ_AFTER_FAILED_CAS: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CAS_WAIT && mem_rsp_valid && !mem_rsp_pmp_fault && !mem_rsp_cas_ok)
        |=> (mem_req_valid && !mem_req_we && $stable(mem_req_addr))); // R10

endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic [1:0]  req_acc = '0;
    logic        req_priv = 1'b0;
    logic        req_sum = 1'b0;
    logic        req_mxr = 1'b0;
    logic        req_hw_ad = 1'b0;
    logic [21:0] root_ppn = 22'h00100;
    logic        ss_fault = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_we;
    logic [33:0] mem_req_addr;
    logic [31:0] mem_req_cmp;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic        mem_rsp_pmp_fault = 1'b0;
    logic        mem_rsp_cas_ok = 1'b0;
    logic        done;
    logic [33:0] pa;
    logic        page_fault;
    logic        access_fault;

    always #2 clk = ~clk;

    pt_walker i_pt_walker (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .req_acc(req_acc), .req_priv(req_priv), .req_sum(req_sum),
        .req_mxr(req_mxr), .req_hw_ad(req_hw_ad), .root_ppn(root_ppn),
        .ss_fault(ss_fault),
        .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
        .mem_req_addr(mem_req_addr), .mem_req_cmp(mem_req_cmp),
        .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .mem_rsp_pmp_fault(mem_rsp_pmp_fault), .mem_rsp_cas_ok(mem_rsp_cas_ok),
        .done(done), .pa(pa), .page_fault(page_fault), .access_fault(access_fault)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // bench memory model
    logic [31:0] mem [logic [33:0]];
    logic [33:0] rd_fault_addr = '1;
    bit          wr_fault = 0;
    bit          interf_on = 0;
    logic [33:0] interf_addr = '0;
    logic [31:0] interf_val = '0;
    logic [33:0] rd_log[$];
    int          n_writes = 0;
    int          n_done = 0;
    bit          busy = 0;

    int          pend = 0;
    logic        p_we;
    logic [33:0] p_addr;
    logic [31:0] p_cmp, p_wdata;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [33:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        mem_rsp_pmp_fault = 1'b0;
        mem_rsp_cas_ok = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                mem_rsp_valid = 1'b1;
                if (!p_we) begin
                    rd_log.push_back(p_addr);
                    mem_rsp_pmp_fault = (p_addr == rd_fault_addr);
                    mem_rsp_rdata = rd(p_addr);
                    if (interf_on && p_addr == interf_addr) begin
                        mem[p_addr] = interf_val;
                        interf_on = 0;
                    end
                end else begin
                    n_writes++;
                    mem_rsp_pmp_fault = wr_fault;
                    mem_rsp_cas_ok = (rd(p_addr) == p_cmp);
                    if (!wr_fault && mem_rsp_cas_ok) mem[p_addr] = p_wdata;
                end
            end
        end
        if (mem_req_valid) begin
            p_we = mem_req_we; p_addr = mem_req_addr;
            p_cmp = mem_req_cmp; p_wdata = mem_req_wdata;
            pend = 2;
        end
        // per-clock comparison of acceptance state against the model (R1)
        if (!rst) begin
            chk(req_ready == !busy, "R1 ready vs model", {63'b0, req_ready}, {63'b0, !busy});
            if (done) begin
                n_done++;
                busy = 0;
            end
        end
    end

    // reference walk, behavioural
    function automatic void ref_walk(input logic [31:0] va, input int acc, input bit priv,
                                     input bit sum, input bit mxr, input bit hwad, input bit ss,
                                     output int kind, output logic [33:0] epa);
        logic [21:0] a;
        logic [31:0] p;
        logic [33:0] ad;
        bit ok, need;
        a = root_ppn;
        kind = 1; epa = '0;
        for (int i = 1; i >= 0; i--) begin
            ad = {a, (i == 1) ? va[31:22] : va[21:12], 2'b00};
            if (ad == rd_fault_addr) begin kind = 2; return; end
            p = rd(ad);
            if (!p[0] || (!p[1] && p[2])) begin kind = 1; return; end
            if (p[1] || p[3]) begin
                if (i == 1 && p[19:10] != 0) begin kind = 1; return; end
                if (!priv && !p[4]) begin kind = 1; return; end
                if (priv && p[4] && (acc == 2 || !sum)) begin kind = 1; return; end
                if (ss) begin kind = 2; return; end
                ok = (acc == 0) ? (p[1] || (p[3] && mxr)) : (acc == 1) ? p[2] : p[3];
                if (!ok) begin kind = 1; return; end
                need = !p[6] || (acc == 1 && !p[7]);
                if (need && !hwad) begin kind = 1; return; end
                if (need && wr_fault) begin kind = 2; return; end
                kind = 0;
                epa = (i == 1) ? {p[31:20], va[21:0]} : {p[31:10], va[11:0]};
                return;
            end
            a = p[31:10];
        end
        kind = 1;
    endfunction

    function automatic logic [31:0] mk(input logic [21:0] ppn, input logic [7:0] fl);
        return {ppn, 2'b00, fl};
    endfunction

    localparam logic [7:0] FV = 8'h01, FR = 8'h02, FW = 8'h04, FX = 8'h08,
                           FU = 8'h10, FA = 8'h40, FD = 8'h80;

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    int          got_kind;
    logic [33:0] got_pa;

    task automatic walk(input logic [31:0] va, input int acc, input bit priv, input bit sum,
                        input bit mxr, input bit hwad, input bit ss);
        int t;
        @(negedge clk);
        req_va = va; req_acc = acc[1:0]; req_priv = priv; req_sum = sum;
        req_mxr = mxr; req_hw_ad = hwad; ss_fault = ss;
        req_valid = 1'b1;
        @(negedge clk);
        busy = 1;
        req_valid = 1'b0;
        t = 0;
        while (!done && t < 200) begin @(negedge clk); t++; end
        got_kind = done ? (page_fault ? 1 : access_fault ? 2 : 0) : 9;
        got_pa = pa;
        if (done) begin
            @(negedge clk);
        end
        ss_fault = 1'b0;
    endtask

    task automatic run_check(input string tag, input logic [31:0] va, input int acc, input bit priv,
                             input bit sum, input bit mxr, input bit hwad, input bit ss);
        int ek;
        logic [33:0] ep;
        ref_walk(va, acc, priv, sum, mxr, hwad, ss, ek, ep);
        walk(va, acc, priv, sum, mxr, hwad, ss);
        chk(got_kind == ek, {tag, " kind"}, 64'(got_kind), 64'(ek));
        if (ek == 0) chk(got_pa == ep, {tag, " pa"}, 64'(got_pa), 64'(ep));
    endtask

    function automatic logic [31:0] va_of(input logic [9:0] v1, input logic [9:0] v0, input logic [11:0] off);
        return {v1, v0, off};
    endfunction

    localparam logic [33:0] L1 = {22'h00100, 12'h0};
    localparam logic [33:0] L0 = {22'h00200, 12'h0};

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
        finish_run();
    end

    initial begin
        int w0, n0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready === 1'b1, "R1 reset ready", {63'b0, req_ready}, 64'h1);
        chk(done === 1'b0, "R1 reset done", {63'b0, done}, 64'h0);
        chk(mem_req_valid === 1'b0, "R1 reset mem", {63'b0, mem_req_valid}, 64'h0);

        // tables: level-1 index 1 points to L0 table
        mem[L1 + 4*1] = mk(22'h00200, FV);
        mem[L0 + 4*0] = mk(22'h12345, FV|FR|FW|FA|FD);
        mem[L0 + 4*1] = mk(22'h00777, FV|FR|FA);
        mem[L0 + 4*2] = mk(22'h00888, FV|FR|FW|FA);
        mem[L0 + 4*3] = mk(22'h00999, 8'h00);
        mem[L0 + 4*4] = mk(22'h00aaa, FV|FW);
        mem[L0 + 4*5] = mk(22'h00bbb, FV);
        mem[L0 + 4*6] = mk(22'h00ccc, FV|FX|FA);
        mem[L0 + 4*7] = mk(22'h00ddd, FV|FR|FU|FA);
        mem[L0 + 4*8] = mk(22'h00eee, FV|FR|FX|FU|FA);
        mem[L0 + 4*9] = mk(22'h01111, FV|FR|FW);
        mem[L1 + 4*2] = mk(22'h2AC00, FV|FR|FW|FA|FD);
        mem[L1 + 4*3] = mk(22'h2AC05, FV|FR|FW|FA|FD);

        // R2 R11 4 KiB load
        rd_log.delete();
        run_check("R11 4K load", va_of(10'd1, 10'd0, 12'hABC), 0, 1, 0, 0, 0, 0);
        chk(rd_log.size() == 2, "R2 read count", 64'(rd_log.size()), 64'd2);
        if (rd_log.size() == 2) begin
            chk(rd_log[0] == L1 + 4, "R2 first addr", 64'(rd_log[0]), 64'(L1 + 4));
            chk(rd_log[1] == L0, "R2 second addr", 64'(rd_log[1]), 64'(L0));
        end

        // R11 superpage
        run_check("R11 superpage", va_of(10'd2, 10'h155, 12'h123), 1, 1, 0, 0, 0, 0);
        // R5 misaligned superpage, shadow-stack also failing -> page fault first
        run_check("R5 misaligned", va_of(10'd3, 10'd0, 12'h0), 0, 1, 0, 0, 0, 1);

        // R4
        run_check("R4 invalid", va_of(10'd1, 10'd3, 12'h0), 0, 1, 0, 0, 0, 0);
        run_check("R4 w-only", va_of(10'd1, 10'd4, 12'h0), 1, 1, 0, 0, 0, 0);
        run_check("R4 pointer at last level", va_of(10'd1, 10'd5, 12'h0), 0, 1, 0, 0, 0, 0);
        run_check("R4 empty root", va_of(10'd9, 10'd0, 12'h0), 0, 1, 0, 0, 0, 0);

        // R6
        run_check("R6 user on sup page", va_of(10'd1, 10'd0, 12'h0), 0, 0, 0, 0, 0, 0);
        run_check("R6 sup load user sum0", va_of(10'd1, 10'd7, 12'h0), 0, 1, 0, 0, 0, 0);
        run_check("R6 sup load user sum1", va_of(10'd1, 10'd7, 12'h010), 0, 1, 1, 0, 0, 0);
        run_check("R6 sup fetch user", va_of(10'd1, 10'd8, 12'h0), 2, 1, 1, 0, 0, 0);
        run_check("R6 user fetch user", va_of(10'd1, 10'd8, 12'h4), 2, 0, 0, 0, 0, 0);

        // R7 ordering
        run_check("R7 user fail beats ss", va_of(10'd1, 10'd0, 12'h0), 0, 0, 0, 0, 0, 1);
        run_check("R7 ss alone", va_of(10'd1, 10'd0, 12'h0), 0, 1, 0, 0, 0, 1);
        run_check("R7 ss beats rwx", va_of(10'd1, 10'd1, 12'h0), 1, 1, 0, 0, 0, 1);

        // R8
        run_check("R8 store read-only", va_of(10'd1, 10'd1, 12'h0), 1, 1, 0, 0, 0, 0);
        run_check("R8 load xonly mxr0", va_of(10'd1, 10'd6, 12'h0), 0, 1, 0, 0, 0, 0);
        run_check("R8 load xonly mxr1", va_of(10'd1, 10'd6, 12'h8), 0, 1, 0, 1, 0, 0);
        run_check("R8 fetch no x", va_of(10'd1, 10'd0, 12'h0), 2, 1, 0, 0, 0, 0);

        // R9 dirty needed, hw update off
        w0 = n_writes;
        run_check("R9 no hw ad", va_of(10'd1, 10'd2, 12'h0), 1, 1, 0, 0, 0, 0);
        chk(n_writes == w0, "R9 no write", 64'(n_writes), 64'(w0));

        // R10 hw update sets D
        run_check("R10 hw ad store", va_of(10'd1, 10'd2, 12'h44), 1, 1, 0, 0, 1, 0);
        chk(mem[L0 + 8] == mk(22'h00888, FV|FR|FW|FA|FD), "R10 dirty set",
            64'(mem[L0 + 8]), 64'(mk(22'h00888, FV|FR|FW|FA|FD)));

        // R10 compare failure: entry changes between read and write
        interf_on = 1; interf_addr = L0 + 4*9; interf_val = mk(22'h02222, FV|FR|FW|FA);
        rd_log.delete();
        walk(va_of(10'd1, 10'd9, 12'h321), 0, 1, 0, 0, 1, 0);
        chk(got_kind == 0, "R10 retry kind", 64'(got_kind), 64'd0);
        chk(got_pa == {22'h02222, 12'h321}, "R10 retry pa", 64'(got_pa), 64'({22'h02222, 12'h321}));
        chk(rd_log.size() == 3, "R10 reread count", 64'(rd_log.size()), 64'd3);
        if (rd_log.size() == 3)
            chk(rd_log[2] == L0 + 4*9, "R10 reread addr", 64'(rd_log[2]), 64'(L0 + 4*9));

        // R10 write protection fault
        mem[L0 + 4*10] = mk(22'h03333, FV|FR);
        wr_fault = 1;
        run_check("R10 write fault", va_of(10'd1, 10'd10, 12'h0), 0, 1, 0, 0, 1, 0);
        wr_fault = 0;

        // R3 read protection fault at second level
        rd_fault_addr = L0;
        run_check("R3 read fault", va_of(10'd1, 10'd0, 12'h0), 0, 1, 0, 0, 0, 0);
        rd_fault_addr = '1;

        // R1 request while busy is ignored; R12 one done per walk
        n0 = n_done;
        rd_log.delete();
        @(negedge clk);
        req_va = va_of(10'd1, 10'd0, 12'h0); req_acc = 2'd0; req_priv = 1'b1;
        req_valid = 1'b1;
        @(negedge clk);
        busy = 1;
        req_valid = 1'b0;
        @(negedge clk);
        req_va = va_of(10'd2, 10'd0, 12'h0); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (30) @(negedge clk);
        chk(n_done - n0 == 1, "R12 single done", 64'(n_done - n0), 64'd1);
        chk(rd_log.size() == 2, "R1 busy request ignored", 64'(rd_log.size()), 64'd2);

        finish_run();
    end

endmodule